// File: doc/BRIEF.md
# Zero-Crossing Gated Gain Updater

This block sits between a control port that delivers new 8-bit gain codes and the analog switch network of a four-channel volume control. For every channel it holds the active gain code, which the switch network applies. A new code can be applied at once, or it can be held back until the channel's input signal crosses zero on a rising slope. Changing gain at that instant avoids audible clicks. When the signal never crosses zero, a 16 ms timeout measured with an external 1 ms tick forces the change. Each channel also decodes its active code into a mute flag and a signed gain value in half-dB steps.

Each channel has its own update port, made up of a valid strobe, an 8-bit code and a ready output. Ready is held high: the block never applies back-pressure, so a code offered with valid high is taken on that clock edge. A new update replaces any code that is still waiting. The input sign of each channel comes from an external comparator, where 1 means negative. The zero-cross enable is shared by all channels.

Top module: `zc_gain_updater`

## Requirements
- R1: After reset every active code is 0, every mute flag is 1 and every gain value is 0.
- R2: With the zero-cross enable low, a code accepted on an update port becomes that channel's active code at the same clock edge.
- R3: With the enable high, an accepted code does not change the active code until a release occurs. A falling sign edge (non-negative to negative) is not a release.
- R4: A rising crossing releases the waiting code: the sign sampled at the previous edge is 1 (negative) and the current sign is 0. The active code then takes the waiting code at that edge.
- R5: With no crossing, the waiting code is applied at the edge of the 16th tick-high cycle after the update cycle. A tick in the update cycle itself does not count.
- R6: An update to a channel that is already waiting replaces the waiting code and restarts the tick count from zero. An update that arrives in the same cycle as a crossing or a final tick wins, and that crossing or tick is ignored.
- R7: If the enable goes low while a channel is waiting, the waiting code is applied at the next edge.
- R8: Active code 0 gives mute = 1 and gain value 0 (unity).
- R9: Active code N from 1 to 255 gives mute = 0 and a 9-bit two's-complement gain value of N − 192, in half-dB units, so 255 gives +63 and 1 gives −191.
- R10: Updates, crossings and timeouts on one channel never change another channel's outputs.
- R11: Every update-ready output stays 1 at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| zc_en | input | 1 | Zero-cross gating enable, shared by all channels |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| sign_neg | input | 4 | Comparator sign per channel, 1 = negative |
| upd_valid | input | 4 | Update valid per channel |
| upd_code | input | 32 | Update gain code, channel c in bits [8c+7:8c] |
| upd_ready | output | 4 | Update ready per channel, always 1 |
| act_code | output | 32 | Active gain code, channel c in bits [8c+7:8c] |
| mute | output | 4 | Mute flag per channel |
| gain_hdb | output | 36 | Signed gain in half-dB units, channel c in bits [9c+8:9c] |

## Verification
There are two same-cycle collisions: a fresh update can meet a release, either a rising crossing or the final timeout tick. The bench provokes one by taking a channel's sign high, then dropping it in the very cycle a new code is offered. It then checks that the old active code survives several more cycles, and that only a later release applies the new code. A second collision comes from re-updating a channel in the middle of a timeout. The bench then confirms that the change lands exactly 16 ticks after the second update, not the first.

// File: rtl/zcg_pkg.sv
package zcg_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } zc_state_e;
endpackage

// File: rtl/zcg_edge_det.sv
module zcg_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sign_neg,
  output logic rise
);
  logic sign_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sign_q <= 1'b0;
    else        sign_q <= sign_neg;
  end

  // negative at the previous sample, non-negative now
  assign rise = sign_q & ~sign_neg;
endmodule

// File: rtl/zcg_timer.sv
module zcg_timer #(
  parameter int TIMEOUT_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

  logic [CNT_W-1:0] cnt;

  assign expire = run & tick & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clear || !run)  cnt <= '0;
    else if (expire)         cnt <= '0;
    else if (tick)           cnt <= cnt + 1'b1;
  end

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < TIMEOUT_TICKS);
endmodule

// File: rtl/zcg_decode.sv
module zcg_decode #(
  parameter int CODE_W  = 8,
  parameter int TOP_HDB = 63
) (
  input  logic [CODE_W-1:0]        code,
  output logic                     mute,
  output logic signed [CODE_W:0]   gain
);
  localparam int GAIN_W = CODE_W + 1;
  localparam int OFFSET = (1 << CODE_W) - 1 - TOP_HDB;

  always_comb begin
    mute = (code == '0);
    if (mute) gain = '0;
    else      gain = $signed(GAIN_W'(code)) - $signed(GAIN_W'(OFFSET));
  end
endmodule

// File: rtl/zcg_channel.sv
module zcg_channel
  import zcg_pkg::*;
#(
  parameter int CODE_W        = 8,
  parameter int TIMEOUT_TICKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zc_en,
  input  logic              tick,
  input  logic              sign_neg,
  input  logic              upd_valid,
  input  logic [CODE_W-1:0] upd_code,
  output logic [CODE_W-1:0] act_code
);
  zc_state_e         st, st_n;
  logic [CODE_W-1:0] pend, pend_n, act, act_n;
  logic              rise, expire, restart;

  zcg_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sign_neg (sign_neg),
    .rise     (rise)
  );

  zcg_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (restart),
    .run    (st == ST_WAIT),
    .tick   (tick),
    .expire (expire)
  );

  always_comb begin
    st_n    = st;
    pend_n  = pend;
    act_n   = act;
    restart = 1'b0;
    if (upd_valid) begin
      if (!zc_en) begin
        act_n = upd_code;
        st_n  = ST_IDLE;
      end else begin
        pend_n  = upd_code;
        st_n    = ST_WAIT;
        restart = 1'b1;
      end
    end else if (st == ST_WAIT) begin
      if (!zc_en || rise || expire) begin
        act_n = pend;
        st_n  = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      pend <= '0;
      act  <= '0;
    end else begin
      st   <= st_n;
      pend <= pend_n;
      act  <= act_n;
    end
  end

  assign act_code = act;

  p_direct_apply_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !zc_en) |=> (act == $past(upd_code)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && zc_en && !upd_valid && !rise && !expire) |=> $stable(act));

  p_cross_apply_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && zc_en && !upd_valid && rise) |=> (act == $past(pend) && st == ST_IDLE));

  p_update_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && zc_en) |=> (st == ST_WAIT && pend == $past(upd_code) && $stable(act)));

  p_enable_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !zc_en && !upd_valid) |=> (act == $past(pend)));
endmodule

// File: rtl/zc_gain_updater.sv
module zc_gain_updater #(
  parameter int NUM_CH        = 4,
  parameter int CODE_W        = 8,
  parameter int TOP_HDB       = 63,
  parameter int TIMEOUT_TICKS = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         zc_en,
  input  logic                         tick_1ms,
  input  logic [NUM_CH-1:0]            sign_neg,
  input  logic [NUM_CH-1:0]            upd_valid,
  input  logic [NUM_CH*CODE_W-1:0]     upd_code,
  output logic [NUM_CH-1:0]            upd_ready,
  output logic [NUM_CH*CODE_W-1:0]     act_code,
  output logic [NUM_CH-1:0]            mute,
  output logic [NUM_CH*(CODE_W+1)-1:0] gain_hdb
);
  localparam int GAIN_W = CODE_W + 1;

  assign upd_ready = '1;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CODE_W-1:0]        code_c;
    logic signed [GAIN_W-1:0] gain_c;

    zcg_channel #(
      .CODE_W        (CODE_W),
      .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .zc_en     (zc_en),
      .tick      (tick_1ms),
      .sign_neg  (sign_neg[c]),
      .upd_valid (upd_valid[c]),
      .upd_code  (upd_code[c*CODE_W +: CODE_W]),
      .act_code  (code_c)
    );

    zcg_decode #(
      .CODE_W  (CODE_W),
      .TOP_HDB (TOP_HDB)
    ) u_dec (
      .code (code_c),
      .mute (mute[c]),
      .gain (gain_c)
    );

    assign act_code[c*CODE_W +: CODE_W] = code_c;
    assign gain_hdb[c*GAIN_W +: GAIN_W] = gain_c;
  end
endmodule

// File: tb/tb_zc_gain_updater.sv
module tb_zc_gain_updater;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        zc_en = 1'b0;
  logic        tick_1ms = 1'b0;
  logic [3:0]  sign_neg = '0;
  logic [3:0]  upd_valid = '0;
  logic [31:0] upd_code = '0;
  logic [3:0]  upd_ready;
  logic [31:0] act_code;
  logic [3:0]  mute;
  logic [35:0] gain_hdb;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct { int ch; int code; } exp_t;
  exp_t sb_q[$];

  zc_gain_updater dut (
    .clk(clk), .rst_n(rst_n), .zc_en(zc_en), .tick_1ms(tick_1ms),
    .sign_neg(sign_neg), .upd_valid(upd_valid), .upd_code(upd_code),
    .upd_ready(upd_ready), .act_code(act_code), .mute(mute), .gain_hdb(gain_hdb)
  );

  always #2.5 clk = ~clk;

  function automatic int code_of(int ch);
    return int'(act_code[ch*8 +: 8]);
  endfunction

  function automatic int gain_of(int ch);
    logic signed [8:0] g;
    g = gain_hdb[ch*9 +: 9];
    return int'(g);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(int ch, int code);
    exp_t e;
    e.ch = ch; e.code = code;
    sb_q.push_back(e);
  endtask

  task automatic upd(int ch, int code);
    upd_valid[ch] = 1'b1;
    upd_code[ch*8 +: 8] = 8'(code);
    @(negedge clk);
    upd_valid[ch] = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_1ms = 1'b1;
      @(negedge clk);
      tick_1ms = 1'b0;
      @(negedge clk);
    end
  endtask

  // monitor: every observed change of an active code must match the queue head
  int prev_code [NCH];
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) prev_code[c] = 0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (code_of(c) != prev_code[c]) begin
          if (sb_q.size() == 0) begin
            check(1'b0, "R10 unexpected change", code_of(c), prev_code[c]);
          end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.ch == c, "R10 channel of change", c, e.ch);
            check(code_of(c) == e.code, "R3 scoreboard code", code_of(c), e.code);
            if (code_of(c) == 0) begin
              check(mute[c] == 1'b1, "R8 mute flag", int'(mute[c]), 1);
              check(gain_of(c) == 0, "R8 gain at mute", gain_of(c), 0);
            end else begin
              check(mute[c] == 1'b0, "R9 mute flag", int'(mute[c]), 0);
              check(gain_of(c) == code_of(c) - 192, "R9 gain value", gain_of(c), code_of(c) - 192);
            end
          end
          prev_code[c] = code_of(c);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles >= 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    for (int c = 0; c < NCH; c++) begin
      check(code_of(c) == 0, "R1 code after reset", code_of(c), 0);
      check(mute[c] == 1'b1, "R1 mute after reset", int'(mute[c]), 1);
      check(gain_of(c) == 0, "R1 gain after reset", gain_of(c), 0);
    end
    check(upd_ready == 4'hF, "R11 ready", int'(upd_ready), 15);

    // R2 and R9: direct apply with gating off
    push(0, 255); upd(0, 255);
    check(code_of(0) == 255, "R2 direct apply ch0", code_of(0), 255);
    check(gain_of(0) == 63, "R9 top gain", gain_of(0), 63);
    push(1, 1); upd(1, 1);
    check(code_of(1) == 1, "R2 direct apply ch1", code_of(1), 1);
    check(gain_of(1) == -191, "R9 bottom gain", gain_of(1), -191);

    // R3, R4, R10: held until a rising crossing
    zc_en = 1'b1;
    upd(2, 200);
    step(1);
    sign_neg[2] = 1'b1;          // falling edge, must not release
    step(2);
    check(code_of(2) == 0, "R3 held over falling edge", code_of(2), 0);
    sign_neg[1] = 1'b1; step(1);
    sign_neg[1] = 1'b0; step(1); // crossing on idle ch1
    check(code_of(1) == 1, "R10 idle channel crossing", code_of(1), 1);
    check(code_of(2) == 0, "R10 other channel crossing", code_of(2), 0);
    push(2, 200);
    sign_neg[2] = 1'b0;
    step(1);
    check(code_of(2) == 200, "R4 crossing release", code_of(2), 200);
    check(gain_of(2) == 8, "R9 mid gain", gain_of(2), 8);

    // R5 timeout
    upd(3, 100);
    ticks(15);
    check(code_of(3) == 0, "R5 held after 15 ticks", code_of(3), 0);
    push(3, 100);
    tick_1ms = 1'b1; step(1); tick_1ms = 1'b0;
    check(code_of(3) == 100, "R5 applied on 16th tick", code_of(3), 100);
    check(upd_ready == 4'hF, "R11 ready while busy", int'(upd_ready), 15);

    // R6 replacement restarts the count
    upd(0, 10);
    ticks(8);
    upd(0, 20);
    ticks(15);
    check(code_of(0) == 255, "R6 restart after replace", code_of(0), 255);
    push(0, 20);
    tick_1ms = 1'b1; step(1); tick_1ms = 1'b0;
    check(code_of(0) == 20, "R6 replaced code applied", code_of(0), 20);

    // R6 update wins over a crossing in the same cycle
    sign_neg[1] = 1'b1; step(1);
    sign_neg[1] = 1'b0;
    upd(1, 30);
    step(3);
    check(code_of(1) == 1, "R6 update beats crossing", code_of(1), 1);

    // R7 dropping the enable releases it
    push(1, 30);
    zc_en = 1'b0;
    step(1);
    check(code_of(1) == 30, "R7 enable drop release", code_of(1), 30);

    // R8 mute code
    push(0, 0); upd(0, 0);
    check(mute[0] == 1'b1, "R8 mute on code 0", int'(mute[0]), 1);
    check(gain_of(0) == 0, "R8 unity at mute", gain_of(0), 0);

    step(3);
    check(sb_q.size() == 0, "R10 scoreboard drained", sb_q.size(), 0);
    check(upd_ready == 4'hF, "R11 ready at end", int'(upd_ready), 15);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule